// File: doc/BRIEF.md
# Descriptor Fetch and Update Sequencer

The block is the bus-master engine a network controller uses to read and update the entries of its receive and transmit descriptor rings. An internal requester hands over a doubleword-aligned descriptor base address, a direction flag, an end-of-packet flag and a software-mode flag. It also hands over, for writes, two data words with their lane masks. The block then requests the bus with HOLD, waits for HLDA, and runs one or two single-beat doubleword cycles. Each cycle waits for a ready input. At the end it drops HOLD and pulses `done`.

The order of the word offsets depends on the software mode and the direction. An update of a chained descriptor that does not end a packet is cut down to a single cycle. That cycle goes to the word holding the ownership bit, so ownership is handed back last. Reads enable every byte lane, and the requester takes the fields it needs from the two returned words, each tagged with its offset. A bus preemption request never cuts a descriptor transfer short. After a preempted transfer the block waits one extra idle cycle before it accepts the next request, which gives the bus to the other master.

Top module: `desc_xfer_seq`

## Requirements
- R1: A request (`req_valid` high) is taken only while `req_ready` is high. `req_ready` is high and `hold` low after reset. A request raised while a transfer runs is dropped and changes neither the running transfer nor the bus afterwards.
- R2: In the cycle after a request is taken, `hold` is high. `bus_cyc` stays low until `hlda` has been seen high at a clock edge, and `bus_cyc` is never high without `hold`.
- R3: Each doubleword is a separate cycle with `bus_cyc` high. The cycle ends at the first clock edge with `bus_rdy` high. Until then, `bus_addr`, `bus_be` and `bus_wdata` stay unchanged.
- R4: A read (`req_write`=0) is always two cycles. With `req_mode32`=1 the offsets are 0x04 then 0x00. With `req_mode32`=0 they are 0x00 then 0x04.
- R5: A write with `req_eop`=1 is two cycles. With `req_mode32`=1 the offsets are 0x08 then 0x04. With `req_mode32`=0 they are 0x04 then 0x00.
- R6: A write with `req_eop`=0 is one cycle, to the ownership word: offset 0x04 with `req_mode32`=1 and 0x00 with `req_mode32`=0.
- R7: Read cycles drive `bus_be`=4'b1111 and `bus_wr`=0. Write cycles drive `bus_wr`=1. At the ownership word (the second offset of a full update, or the only offset of a single write) they drive `wr_own_data`/`wr_own_be`. At the other word they drive `wr_aux_data`/`wr_aux_be`. The values used are those latched when the request was taken.
- R8: `bus_addr` = {base[31:8], (base[7:0] + offset) mod 256}. Bits 31:8 therefore never change within one transfer, and bits 1:0 are zero.
- R9: `preempt` does not shorten a transfer, and `hold` stays high until the last cycle has ended. If `preempt` was high at any edge while `hold` was high, `req_ready` stays low for one cycle after the `done` pulse.
- R10: In the cycle after the last ready edge, `done` is high for one cycle with `hold` and `bus_cyc` low. For reads, `rd_word0`/`rd_off0` then hold the data and offset of the first cycle, and `rd_word1`/`rd_off1` hold those of the second.
- R11: A request whose base has nonzero bits 1:0 produces a one-cycle `err` pulse in the next cycle. No bus cycle starts, `hold` stays low and the block stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Descriptor access request |
| req_base | input | 32 | Descriptor base address |
| req_write | input | 1 | 1 = update descriptor, 0 = fetch |
| req_eop | input | 1 | Descriptor ends a packet (full update) |
| req_mode32 | input | 1 | 1 = 32-bit software layout, 0 = 16-bit |
| wr_aux_data | input | 32 | Data for the non-ownership word |
| wr_aux_be | input | 4 | Lane mask for the non-ownership word |
| wr_own_data | input | 32 | Data for the ownership word |
| wr_own_be | input | 4 | Lane mask for the ownership word |
| req_ready | output | 1 | Block idle and able to take a request |
| hold | output | 1 | Bus request |
| hlda | input | 1 | Bus grant |
| preempt | input | 1 | Another master asks for the bus back |
| bus_cyc | output | 1 | Bus cycle active |
| bus_wr | output | 1 | Bus cycle direction, 1 = write |
| bus_addr | output | 32 | Bus address |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Write data |
| bus_rdy | input | 1 | Current bus cycle completes |
| bus_rdata | input | 32 | Read data |
| done | output | 1 | Transfer finished pulse |
| err | output | 1 | Misaligned request pulse |
| rd_word0 | output | 32 | Data of first read cycle |
| rd_off0 | output | 8 | Offset of first read cycle |
| rd_word1 | output | 32 | Data of second read cycle |
| rd_off1 | output | 8 | Offset of second read cycle |

## Verification
The hardest case to reach is a request arriving while a transfer is stalled on `bus_rdy`, combined with preemption and a base low byte near 0xFF. In that case the offset addition has to wrap inside bits 7:0. The sweep covers every mode, direction and end-of-packet combination with four base low bytes (0x00, 0x40, 0xF8, 0xFC). It varies the grant delay and the number of wait states. On some runs it raises a competing request with a different base during the wait states, and on others it holds `preempt`. It then checks that the address, the lanes and the idle period that follows come only from the original request.

// File: rtl/desc_pkg.sv
package desc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARB     = 3'd1,
    ST_BEAT    = 3'd2,
    ST_FIN     = 3'd3,
    ST_BACKOFF = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic mode32;
    logic wr;
    logic eop;
  } req_flags_t;

endpackage

// File: rtl/desc_order.sv
module desc_order
  import desc_pkg::*;
#(
  parameter int OFFW = 8
) (
  input  req_flags_t        flags,
  input  logic              beat,
  output logic [OFFW-1:0]   offset,
  output logic              last_beat,
  output logic              own_slot
);

  localparam logic [OFFW-1:0] OFF_00 = OFFW'(0);
  localparam logic [OFFW-1:0] OFF_04 = OFFW'(4);
  localparam logic [OFFW-1:0] OFF_08 = OFFW'(8);

  logic single;

  always_comb begin
    single    = flags.wr && !flags.eop;
    last_beat = beat || single;
    own_slot  = flags.wr && (single || beat);
    if (!flags.wr) begin
      if (flags.mode32) offset = beat ? OFF_00 : OFF_04;
      else              offset = beat ? OFF_04 : OFF_00;
    end else if (own_slot) begin
      offset = flags.mode32 ? OFF_04 : OFF_00;
    end else begin
      offset = flags.mode32 ? OFF_08 : OFF_04;
    end
  end

endmodule

// File: rtl/desc_ctrl.sv
module desc_ctrl
  import desc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       aligned,
  input  logic       hlda,
  input  logic       bus_rdy,
  input  logic       preempt,
  input  logic       last_beat,
  output seq_state_t state,
  output logic       accept,
  output logic       beat,
  output logic       fire,
  output logic       err
);

  seq_state_t state_q, state_d;
  logic       beat_q, beat_d;
  logic       pend_q, pend_d;
  logic       err_q, err_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    pend_d  = pend_q;
    err_d   = 1'b0;
    accept  = (state_q == ST_IDLE) && req_valid && aligned;
    fire    = (state_q == ST_BEAT) && bus_rdy;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (aligned) begin
            state_d = ST_ARB;
            beat_d  = 1'b0;
            pend_d  = 1'b0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_ARB: begin
        if (preempt) pend_d = 1'b1;
        if (hlda) state_d = ST_BEAT;
      end
      ST_BEAT: begin
        if (preempt) pend_d = 1'b1;
        if (bus_rdy) begin
          if (last_beat) state_d = ST_FIN;
          else           beat_d  = 1'b1;
        end
      end
      ST_FIN:  state_d = pend_q ? ST_BACKOFF : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
    end
  end

  assign state = state_q;
  assign beat  = beat_q;
  assign err   = err_q;

endmodule

// File: rtl/desc_dpath.sv
module desc_dpath
  import desc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              fire,
  input  logic              beat,
  input  logic              own_slot,
  input  logic [OFFW-1:0]   offset,
  input  logic [AW-1:0]     req_base,
  input  req_flags_t        req_flags,
  input  logic [DW-1:0]     wr_aux_data,
  input  logic [DW/8-1:0]   wr_aux_be,
  input  logic [DW-1:0]     wr_own_data,
  input  logic [DW/8-1:0]   wr_own_be,
  input  logic [DW-1:0]     bus_rdata,
  output req_flags_t        flags,
  output logic [AW-1:0]     bus_addr,
  output logic [DW/8-1:0]   bus_be,
  output logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     rd_word0,
  output logic [OFFW-1:0]   rd_off0,
  output logic [DW-1:0]     rd_word1,
  output logic [OFFW-1:0]   rd_off1
);

  localparam int BEW = DW / 8;

  logic [AW-1:0]   base_q;
  req_flags_t      flags_q;
  logic [DW-1:0]   aux_d_q, own_d_q;
  logic [BEW-1:0]  aux_be_q, own_be_q;
  logic [DW-1:0]   w0_q, w1_q;
  logic [OFFW-1:0] o0_q, o1_q;
  logic            cap0_en, cap1_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      flags_q  <= '0;
      aux_d_q  <= '0;
      own_d_q  <= '0;
      aux_be_q <= '0;
      own_be_q <= '0;
    end else if (accept) begin
      base_q   <= req_base;
      flags_q  <= req_flags;
      aux_d_q  <= wr_aux_data;
      own_d_q  <= wr_own_data;
      aux_be_q <= wr_aux_be;
      own_be_q <= wr_own_be;
    end
  end

  always_comb begin
    cap0_en = fire && !flags_q.wr && !beat;
    cap1_en = fire && !flags_q.wr && beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      o0_q <= '0;
    end else if (cap0_en) begin
      w0_q <= bus_rdata;
      o0_q <= offset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      o1_q <= '0;
    end else if (cap1_en) begin
      w1_q <= bus_rdata;
      o1_q <= offset;
    end
  end

  always_comb begin
    bus_addr = {base_q[AW-1:OFFW], base_q[OFFW-1:0] + offset};
    if (!flags_q.wr) begin
      bus_be    = '1;
      bus_wdata = '0;
    end else if (own_slot) begin
      bus_be    = own_be_q;
      bus_wdata = own_d_q;
    end else begin
      bus_be    = aux_be_q;
      bus_wdata = aux_d_q;
    end
  end

  assign flags    = flags_q;
  assign rd_word0 = w0_q;
  assign rd_off0  = o0_q;
  assign rd_word1 = w1_q;
  assign rd_off1  = o1_q;

endmodule

// File: rtl/desc_xfer_seq.sv
module desc_xfer_seq
  import desc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_base,
  input  logic              req_write,
  input  logic              req_eop,
  input  logic              req_mode32,
  input  logic [DW-1:0]     wr_aux_data,
  input  logic [DW/8-1:0]   wr_aux_be,
  input  logic [DW-1:0]     wr_own_data,
  input  logic [DW/8-1:0]   wr_own_be,
  output logic              req_ready,
  output logic              hold,
  input  logic              hlda,
  input  logic              preempt,
  output logic              bus_cyc,
  output logic              bus_wr,
  output logic [AW-1:0]     bus_addr,
  output logic [DW/8-1:0]   bus_be,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_rdy,
  input  logic [DW-1:0]     bus_rdata,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rd_word0,
  output logic [OFFW-1:0]   rd_off0,
  output logic [DW-1:0]     rd_word1,
  output logic [OFFW-1:0]   rd_off1
);

  seq_state_t      state;
  req_flags_t      in_flags, flags;
  logic            aligned, accept, beat, fire, last_beat, own_slot;
  logic [OFFW-1:0] offset;

  always_comb begin
    aligned         = (req_base[1:0] == 2'b00);
    in_flags.mode32 = req_mode32;
    in_flags.wr     = req_write;
    in_flags.eop    = req_eop;
  end

  desc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .aligned   (aligned),
    .hlda      (hlda),
    .bus_rdy   (bus_rdy),
    .preempt   (preempt),
    .last_beat (last_beat),
    .state     (state),
    .accept    (accept),
    .beat      (beat),
    .fire      (fire),
    .err       (err)
  );

  desc_order #(.OFFW(OFFW)) u_order (
    .flags     (flags),
    .beat      (beat),
    .offset    (offset),
    .last_beat (last_beat),
    .own_slot  (own_slot)
  );

  desc_dpath #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .fire        (fire),
    .beat        (beat),
    .own_slot    (own_slot),
    .offset      (offset),
    .req_base    (req_base),
    .req_flags   (in_flags),
    .wr_aux_data (wr_aux_data),
    .wr_aux_be   (wr_aux_be),
    .wr_own_data (wr_own_data),
    .wr_own_be   (wr_own_be),
    .bus_rdata   (bus_rdata),
    .flags       (flags),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .rd_word0    (rd_word0),
    .rd_off0     (rd_off0),
    .rd_word1    (rd_word1),
    .rd_off1     (rd_off1)
  );

  always_comb begin
    req_ready = (state == ST_IDLE);
    hold      = (state == ST_ARB) || (state == ST_BEAT);
    bus_cyc   = (state == ST_BEAT);
    bus_wr    = (state == ST_BEAT) && flags.wr;
    done      = (state == ST_FIN);
  end

endmodule

// File: rtl/desc_xfer_seq_chk.sv
module desc_xfer_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold,
  input logic            hlda,
  input logic            preempt,
  input logic            bus_cyc,
  input logic            bus_wr,
  input logic            bus_rdy,
  input logic [AW-1:0]   bus_addr,
  input logic [DW/8-1:0] bus_be,
  input logic            done,
  input logic            err
);

  assert_cyc_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> hold && hlda);

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_rdy |=> bus_cyc && $stable(bus_addr) && $stable(bus_be));

  assert_read_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_wr |-> bus_be == '1);

  assert_upper_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && $past(bus_cyc) |-> $stable(bus_addr[AW-1:8]));

  assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> bus_addr[1:0] == 2'b00);

  assert_preempt_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && preempt && !bus_rdy |=> hold);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hold && !bus_cyc);

  assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> done);

  assert_err_no_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !hold && !bus_cyc);

endmodule

bind desc_xfer_seq desc_xfer_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold    (hold),
  .hlda    (hlda),
  .preempt (preempt),
  .bus_cyc (bus_cyc),
  .bus_wr  (bus_wr),
  .bus_rdy (bus_rdy),
  .bus_addr(bus_addr),
  .bus_be  (bus_be),
  .done    (done),
  .err     (err)
);

// File: tb/desc_xfer_seq_bench.sv
`timescale 1ns/1ps
module desc_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_base = '0;
  logic        req_write = 1'b0, req_eop = 1'b0, req_mode32 = 1'b0;
  logic [31:0] wr_aux_data = '0, wr_own_data = '0;
  logic [3:0]  wr_aux_be = '0, wr_own_be = '0;
  logic        hlda = 1'b0, preempt = 1'b0, bus_rdy = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        req_ready, hold, bus_cyc, bus_wr, done, err;
  logic [31:0] bus_addr, bus_wdata, rd_word0, rd_word1;
  logic [3:0]  bus_be;
  logic [7:0]  rd_off0, rd_off1;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  desc_xfer_seq u_desc_xfer_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_write(req_write), .req_eop(req_eop), .req_mode32(req_mode32),
    .wr_aux_data(wr_aux_data), .wr_aux_be(wr_aux_be),
    .wr_own_data(wr_own_data), .wr_own_be(wr_own_be),
    .req_ready(req_ready), .hold(hold), .hlda(hlda), .preempt(preempt),
    .bus_cyc(bus_cyc), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .done(done), .err(err), .rd_word0(rd_word0), .rd_off0(rd_off0),
    .rd_word1(rd_word1), .rd_off1(rd_off1)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_off(bit m32, bit wr, bit eop, int b);
    if (!wr)      return m32 ? (b == 1 ? 8'h00 : 8'h04) : (b == 1 ? 8'h04 : 8'h00);
    else if (!eop) return m32 ? 8'h04 : 8'h00;
    else          return m32 ? (b == 1 ? 8'h04 : 8'h08) : (b == 1 ? 8'h00 : 8'h04);
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[7:0], 8'h5A, ~a[7:0], a[15:8]};
  endfunction

  task automatic run_xfer(input bit m32, input bit wr, input bit eop,
                          input logic [31:0] base, input int waits,
                          input int gdly, input bit pre, input bit intrude);
    int nb;
    logic [31:0] ea, adata, odata;
    logic [3:0]  abe, obe, ebe;
    logic [31:0] got [2];
    logic [7:0]  goff [2];
    string rtag;
    bit own;
    nb    = (wr && !eop) ? 1 : 2;
    rtag  = !wr ? "R4" : (eop ? "R5" : "R6");
    adata = base ^ 32'h1357_9BDF;
    odata = ~base;
    abe   = base[5:2] | 4'b0001;
    obe   = {1'b1, base[4:2]};
    @(negedge clk);
    check(req_ready === 1'b1, "R1 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_base = base; req_write = wr; req_eop = eop; req_mode32 = m32;
    wr_aux_data = adata; wr_aux_be = abe; wr_own_data = odata; wr_own_be = obe;
    @(negedge clk);
    req_valid = 1'b0;
    req_base = 32'hDEAD_BEE0; req_write = ~wr; req_eop = ~eop; req_mode32 = ~m32;
    wr_aux_data = '0; wr_own_data = '0; wr_aux_be = '0; wr_own_be = '0;
    check(hold === 1'b1, "R2 hold after accept", {31'd0, hold}, 32'd1);
    check(bus_cyc === 1'b0, "R2 no cycle before grant", {31'd0, bus_cyc}, 32'd0);
    for (int g = 0; g < gdly; g++) begin
      @(negedge clk);
      check(bus_cyc === 1'b0 && hold === 1'b1, "R2 waiting for grant", {31'd0, bus_cyc}, 32'd0);
    end
    hlda = 1'b1;
    preempt = pre;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      bus_rdy = 1'b0;
      ea  = {base[31:8], base[7:0] + exp_off(m32, wr, eop, b)};
      own = wr && (!eop || b == 1);
      ebe = !wr ? 4'hF : (own ? obe : abe);
      check(bus_cyc === 1'b1, {rtag, " cycle active"}, {31'd0, bus_cyc}, 32'd1);
      check(bus_addr === ea, {rtag, " R8 address order"}, bus_addr, ea);
      check(bus_be === ebe, "R7 lane enables", {28'd0, bus_be}, {28'd0, ebe});
      check(bus_wr === wr, "R7 direction", {31'd0, bus_wr}, {31'd0, wr});
      if (wr)
        check(bus_wdata === (own ? odata : adata), "R7 write data", bus_wdata,
              own ? odata : adata);
      for (int w = 0; w < waits; w++) begin
        req_valid = intrude;
        @(negedge clk);
        check(bus_cyc === 1'b1 && bus_addr === ea, "R3 stall keeps address", bus_addr, ea);
        check(hold === 1'b1, "R9 hold kept under preempt", {31'd0, hold}, 32'd1);
      end
      req_valid = 1'b0;
      bus_rdy   = 1'b1;
      bus_rdata = mem_word(ea);
      got[b]  = mem_word(ea);
      goff[b] = exp_off(m32, wr, eop, b);
    end
    @(negedge clk);
    bus_rdy = 1'b0;
    check(done === 1'b1 && hold === 1'b0 && bus_cyc === 1'b0, "R10 done with hold low",
          {29'd0, done, hold, bus_cyc}, 32'b100);
    if (!wr) begin
      check(rd_word0 === got[0] && rd_off0 === goff[0], "R10 first read word", rd_word0, got[0]);
      check(rd_word1 === got[1] && rd_off1 === goff[1], "R10 second read word", rd_word1, got[1]);
    end
    hlda = 1'b0;
    preempt = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R10 done single cycle", {31'd0, done}, 32'd0);
    check(req_ready === !pre, "R9 backoff after preempt", {31'd0, req_ready}, {31'd0, !pre});
    if (pre) begin
      @(negedge clk);
      check(req_ready === 1'b1, "R9 ready after backoff", {31'd0, req_ready}, 32'd1);
    end
    @(negedge clk);
    check(hold === 1'b0, "R1 dropped request starts nothing", {31'd0, hold}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R0 watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lows [4];
    lows[0] = 8'h00; lows[1] = 8'h40; lows[2] = 8'hF8; lows[3] = 8'hFC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && hold === 1'b0 && bus_cyc === 1'b0 && done === 1'b0 &&
          err === 1'b0, "R1 reset state", {27'd0, req_ready, hold, bus_cyc, done, err},
          32'b10000);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] base;
      bit pre, intr;
      int wt;
      base = {8'h3C, 8'(i * 37), 8'(i * 5), lows[i % 4]};
      wt   = i % 3;
      pre  = ((i >> 1) ^ (i >> 3)) & 1;
      intr = (wt > 0) && ((i >> 2) & 1);
      run_xfer(i[4], i[3], i[2], base, wt, (i >> 1) % 3, pre, intr);
    end
    for (int lb = 1; lb < 4; lb++) begin
      @(negedge clk);
      req_valid = 1'b1; req_base = 32'h0000_1100 | lb; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      check(err === 1'b1 && hold === 1'b0, "R11 misaligned flagged", {30'd0, err, hold}, 32'b10);
      @(negedge clk);
      check(err === 1'b0 && hold === 1'b0 && bus_cyc === 1'b0 && req_ready === 1'b1,
            "R11 no bus cycle", {28'd0, err, hold, bus_cyc, req_ready}, 32'b0001);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule